// File: doc/BRIEF.md
# Two-Key Register Write Protection Gate

This block sits between a peripheral's register bus and its protected control registers, and it keeps software from changing those registers by accident. After reset the gate is shut, and every bus write that targets a protected register is dropped without any response. To open the gate, software writes two fixed key bytes, one after the other, to a dedicated key register. Any other value written to the key register shuts the gate again at once. While the gate is open, ordinary writes to the protected registers go through.

The block gives one write-enable qualifier for each protected register and a lock status flag. The protected registers are modelled by a small stub register file with a read port. The bench uses that read port to show whether a write reached a register. Writes to addresses other than the key register never move the key sequence forward and never reset it.

Top module: `wp_gate`

## Requirements
- R1: While the synchronous active-low reset is held, and in the first cycle after it, `locked` is 1, `reg_we` is all zero and every stub register reads 0.
- R2: A key-register write (offset 0x24) whose low byte is 0xCA, followed later by a key-register write whose low byte is 0x53, clears `locked` in the cycle after the second write. `locked` stays 1 after the first key alone.
- R3: While `locked` is 1, a write to a protected register leaves `reg_we` at zero, and the register keeps its old contents.
- R4: While `locked` is 0, a write strobe to offset 4*i (i from 0 to NREG-1) raises only `reg_we[i]` in the same cycle. The register reads back the written data from the next cycle on.
- R5: From the locked state, a key byte other than 0xCA keeps the gate locked. After 0xCA, a second key byte other than 0x53 (0xCA included) returns the gate to the fully locked state, so a 0x53 that follows does not open it.
- R6: While the gate is open, any write to the key register, including 0xCA, 0x53 or 0xFF, sets `locked` in the next cycle and blocks the next protected write.
- R7: Writes to protected or unmapped addresses, placed between the two key writes or while the gate is open, neither advance nor reset the key sequence.
- R8: Only bits 7:0 of a key-register write are compared. The upper data bits have no effect on the sequence.
- R9: `rd_data` returns the contents of protected register i at offset 4*i, and returns 0 for the key register and for any unmapped or unaligned offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W (10) | Byte offset of the write |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (10) | Byte offset for the read port of the stub registers |
| rd_data | output | DATA_W (32) | Combinational read data |
| reg_we | output | NREG (6) | Qualified write enable, one bit for each protected register |
| locked | output | 1 | 1 while protected writes are blocked |

## Verification
A wrong key-sequencer state shows at the ports within one cycle. A state that unlocks early shows as a `reg_we` pulse, or as changed read data, on the very next protected write. A state that forgets the first key shows as `locked` still being 1 in the cycle after a correct 0x53. A state that fails to relock shows as `locked` still being 0 in the cycle after the offending key write. The bench models the three-state sequence on its own. It compares `locked` after every write, `reg_we` during every write and register contents on reads, under random mixes of keys, protected writes and unmapped writes.

// File: rtl/wp_pkg.sv
// Package: shared types and key constants for the write-protection gate.
// Assumes: key bytes are compared on the low 8 bits of the write data.
package wp_pkg;

    // Key sequencer states: shut, first key accepted, open.
    typedef enum logic [1:0] {
        WP_LOCKED = 2'd0,
        WP_HALF   = 2'd1,
        WP_OPEN   = 2'd2
    } wp_state_e;

    localparam logic [7:0] WP_KEY_FIRST  = 8'hCA;
    localparam logic [7:0] WP_KEY_SECOND = 8'h53;

endpackage

// File: rtl/wp_addr_dec.sv
// Module: wp_addr_dec
// Decodes a write offset into one hit per protected register (offset
// i*STRIDE) and a separate hit for the key register.
// Assumes: KEY_OFFSET does not collide with a protected register offset.
module wp_addr_dec #(
    parameter int ADDR_W     = 10,
    parameter int NREG       = 6,
    parameter int STRIDE     = 4,
    parameter int KEY_OFFSET = 'h24
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   reg_hit,
    output logic              key_hit
);

    localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(KEY_OFFSET);

    // One comparator per protected register offset.
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(i * STRIDE);
        assign reg_hit[i] = (addr == REG_ADDR);
    end

    // Key register comparator.
    assign key_hit = (addr == KEY_ADDR);

endmodule

// File: rtl/wp_key_seq.sv
// Module: wp_key_seq
// Three-state key sequencer. Two key writes in order open the gate. Any
// other key write shuts it. Non-key writes leave the state alone.
// Assumes: key_wr is already qualified with the bus write strobe.
module wp_key_seq
    import wp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      key_wr,
    input  logic [7:0] key_byte,
    output wp_state_e state,
    output logic      is_open
);

    wp_state_e nxt;

    // Next-state selection on a key-register write.
    always_comb begin
        nxt = state;
        if (key_wr) begin
            case (state)
                WP_LOCKED: nxt = (key_byte == WP_KEY_FIRST)  ? WP_HALF : WP_LOCKED;
                WP_HALF:   nxt = (key_byte == WP_KEY_SECOND) ? WP_OPEN : WP_LOCKED;
                default:   nxt = WP_LOCKED;
            endcase
        end
    end

    // State register with synchronous active-low reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WP_LOCKED;
        else        state <= nxt;
    end

    // Gate is open only in the final state.
    assign is_open = (state == WP_OPEN);

endmodule

// File: rtl/wp_stub_regs.sv
// Module: wp_stub_regs
// Stand-in for the protected registers. One register per write enable,
// with a combinational read port by byte offset. Unmapped offsets read 0.
// Assumes: at most one write enable is high per cycle.
module wp_stub_regs #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int NREG   = 6,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Storage for protected register i.
        always_ff @(posedge clk) begin
            if (!rst_n)     regs[i] <= '0;
            else if (we[i]) regs[i] <= wdata;
        end
    end

    // Read mux by offset; anything unmapped returns zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == ADDR_W'(i * STRIDE)) rd_data = regs[i];
        end
    end

endmodule

// File: rtl/wp_gate.sv
// Module: wp_gate (top)
// Write-protection gate in front of NREG protected registers. The key
// sequencer decides whether the gate is open. Decoded write hits are
// qualified with the strobe and the open state, and they drive the stub
// registers.
// Assumes: a single write port, one access per cycle, DATA_W >= 8.
module wp_gate
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int NREG       = 6,
    parameter int STRIDE     = 4,
    parameter int KEY_OFFSET = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NREG-1:0]   reg_we,
    output logic              locked
);

    logic [NREG-1:0] reg_hit;
    logic            key_hit;
    logic            is_open;
    wp_state_e       key_state;

    // Address decode of the write port.
    wp_addr_dec #(
        .ADDR_W(ADDR_W), .NREG(NREG), .STRIDE(STRIDE), .KEY_OFFSET(KEY_OFFSET)
    ) u_dec (
        .addr(wr_addr), .reg_hit(reg_hit), .key_hit(key_hit)
    );

    // Key sequence tracking.
    wp_key_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .key_wr(wr_en && key_hit),
        .key_byte(wr_data[7:0]),
        .state(key_state), .is_open(is_open)
    );

    // Qualified write enables: strobe, decode hit and open gate.
    assign reg_we = reg_hit & {NREG{wr_en && is_open}};
    assign locked = !is_open;

    // Protected register stand-ins.
    wp_stub_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .STRIDE(STRIDE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/wp_gate_chk.sv
// Module: wp_gate_chk
// Property checker for wp_gate, attached with bind. It watches the ports
// and the key sequencer state.
// Assumes: the key register offset matches the top-level parameter.
module wp_gate_chk
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int NREG       = 6,
    parameter int KEY_OFFSET = 'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        key_byte,
    input logic [NREG-1:0]   reg_we,
    input logic              locked,
    input wp_state_e         key_state
);

    logic key_wr;
    assign key_wr = wr_en && (wr_addr == ADDR_W'(KEY_OFFSET));

    // R1: reset leaves the gate locked.
    a_r1_reset_locks: assert property (@(posedge clk) !rst_n |=> locked);

    // R3: no qualified write while locked.
    a_r3_blocked_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (reg_we == '0));

    // R4: at most one register enabled, and only with a strobe.
    a_r4_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we));
    a_r4_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (reg_we == '0));

    // R2: second key after the first opens the gate.
    a_r2_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_byte == 8'h53 && key_state == WP_HALF) |=> !locked);

    // R5: only a 0x53 key write can ever clear the lock.
    a_r5_no_early_open: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(key_wr && key_byte == 8'h53)) |=> locked);

    // R6: any key write while open relocks.
    a_r6_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !locked) |=> locked);

    // R7: non-key cycles hold the sequence state.
    a_r7_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(key_state));

endmodule

bind wp_gate wp_gate_chk #(
    .ADDR_W(ADDR_W), .NREG(NREG), .KEY_OFFSET(KEY_OFFSET)
) u_wp_gate_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .key_byte(wr_data[7:0]), .reg_we(reg_we), .locked(locked),
    .key_state(key_state)
);

// File: tb/wp_gate_bench.sv
// Bench for wp_gate: directed corner cases, then seeded random traffic,
// all checked against a bench-side model of the key sequence.
module wp_gate_bench;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int NREG   = 6;
    localparam logic [ADDR_W-1:0] KEY = 10'h024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NREG-1:0]   reg_we;
    logic              locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int m_state = 0;               // 0 locked, 1 first key seen, 2 open
    logic [DATA_W-1:0] m_regs [NREG];

    always #5 clk = ~clk;

    wp_gate u_wp_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .reg_we(reg_we), .locked(locked)
    );

    function automatic int hit_idx(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < NREG; i++) if (a == ADDR_W'(i * 4)) return i;
        return -1;
    endfunction

    function automatic int next_state(input int s, input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
        if (a != KEY) return s;
        if (s == 0) return (d[7:0] == 8'hCA) ? 1 : 0;
        if (s == 1) return (d[7:0] == 8'h53) ? 2 : 0;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One write: check reg_we mid-cycle, update the model, check locked after.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input string req);
        int idx;
        logic [NREG-1:0] exp_we;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        idx = hit_idx(a);
        exp_we = (m_state == 2 && idx >= 0) ? NREG'(1 << idx) : '0;
        #1;
        check(reg_we == exp_we, req, "reg_we", DATA_W'(reg_we), DATA_W'(exp_we));
        @(posedge clk);
        if (exp_we != '0) m_regs[idx] = d;
        m_state = next_state(m_state, a, d);
        #1;
        wr_en = 1'b0;
        check(locked == (m_state != 2), req, "locked", DATA_W'(locked),
              DATA_W'(m_state != 2));
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string req);
        int idx;
        logic [DATA_W-1:0] exp;
        rd_addr = a;
        #1;
        idx = hit_idx(a);
        exp = (idx >= 0) ? m_regs[idx] : '0;
        check(rd_data == exp, req, "rd_data", rd_data, exp);
    endtask

    task automatic unlock(input string req);
        wr(KEY, 32'h0000_00CA, req);
        wr(KEY, 32'h0000_0053, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        int unsigned seed_val;
        for (int i = 0; i < NREG; i++) m_regs[i] = '0;
        seed_val = $urandom(32'h0000_5EED);

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(locked == 1'b1, "R1", "locked in reset", DATA_W'(locked), 1);
        check(reg_we == '0, "R1", "reg_we in reset", DATA_W'(reg_we), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(locked == 1'b1, "R1", "locked after reset", DATA_W'(locked), 1);
        for (int i = 0; i < NREG; i++) rd(ADDR_W'(i * 4), "R1");

        // R3: protected writes ignored while locked
        wr(10'h004, 32'hDEAD_BEEF, "R3");
        rd(10'h004, "R3");
        wr(10'h014, 32'h0BAD_F00D, "R3");
        rd(10'h014, "R3");

        // R2: first key alone stays locked, second opens
        unlock("R2");
        // R4: every register writable while open
        for (int i = 0; i < NREG; i++) wr(ADDR_W'(i * 4), 32'hA500_0000 + i, "R4");
        for (int i = 0; i < NREG; i++) rd(ADDR_W'(i * 4), "R4");

        // R6: any key write relocks, including the key values themselves
        wr(KEY, 32'h0000_00CA, "R6");
        wr(10'h000, 32'h5555_5555, "R6");
        rd(10'h000, "R6");
        unlock("R6");
        wr(KEY, 32'h0000_0053, "R6");
        unlock("R6");
        wr(KEY, 32'h0000_00FF, "R6");

        // R5: wrong first key, wrong second key, repeated first key
        wr(KEY, 32'h0000_0011, "R5");
        wr(KEY, 32'h0000_0053, "R5");
        wr(KEY, 32'h0000_00CA, "R5");
        wr(KEY, 32'h0000_00CA, "R5");
        wr(KEY, 32'h0000_0053, "R5");
        wr(10'h008, 32'h1111_2222, "R5");
        rd(10'h008, "R5");

        // R7: other writes between the keys do not disturb the sequence
        wr(KEY, 32'h0000_00CA, "R7");
        wr(10'h010, 32'h7777_0000, "R7");
        wr(10'h3F0, 32'h0000_0053, "R7");
        wr(KEY, 32'h0000_0053, "R7");
        wr(10'h00C, 32'h7777_1111, "R7");
        wr(10'h002, 32'h0000_00CA, "R7");
        wr(10'h010, 32'h7777_2222, "R7");
        rd(10'h00C, "R7");
        rd(10'h010, "R7");

        // R8: upper data bits ignored in key compare
        wr(KEY, 32'h0000_00FF, "R8");
        wr(KEY, 32'hFFFF_FFCA, "R8");
        wr(KEY, 32'h1234_5653, "R8");
        wr(KEY, 32'hCA53_CA00, "R8");
        wr(KEY, 32'h0000_0153, "R8");

        // R9: key, unmapped and unaligned offsets read zero
        rd(KEY, "R9");
        rd(10'h3F0, "R9");
        rd(10'h002, "R9");
        rd(10'h018, "R9");

        // Random mix of key, protected and unmapped writes
        for (int n = 0; n < 1500; n++) begin
            int sel;
            logic [DATA_W-1:0] d;
            logic [ADDR_W-1:0] a;
            sel = $urandom_range(0, 9);
            d = $urandom();
            if (sel < 4) begin
                a = KEY;
                case ($urandom_range(0, 3))
                    0: d[7:0] = 8'hCA;
                    1: d[7:0] = 8'h53;
                    2: d[7:0] = 8'hFF;
                    default: ;
                endcase
                wr(a, d, "R2/R5/R6 random key");
            end else if (sel < 8) begin
                a = ADDR_W'($urandom_range(0, NREG - 1) * 4);
                wr(a, d, "R3/R4 random reg");
            end else begin
                a = ($urandom_range(0, 1) == 0) ? 10'h3F0 : 10'h006;
                wr(a, d, "R7 random unmapped");
            end
            rd(ADDR_W'($urandom_range(0, NREG) * 4), "R9 random read");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule